// File: doc/BRIEF.md
# Integer Execute Stage with Immediate Prefix

This block is the execute stage of a 32-bit RISC pipeline. Each cycle it may accept one decoded instruction: an opcode, two register operands, a 16-bit immediate and a flag that chooses whether the second operand comes from the register or from the immediate. It computes one of a fixed set of integer operations: add, add without touching carry, reverse subtract with and without carry update, four bitwise logic functions, and a one-bit arithmetic right shift. The result and the carry flag are registered. A valid strobe leaves the block one cycle after the instruction went in.

A prefix instruction lets software build a full 32-bit immediate. It stores its 16-bit immediate as the upper half of the next immediate operand. A two-state machine tracks whether a prefix is pending. `PFX_IDLE` means no prefix is held and `PFX_ARMED` means one is held. The transitions are as follows:

- `T_ARM` goes from idle to armed when a prefix is accepted.
- `T_REARM` keeps the machine armed when another prefix arrives and replaces the held half.
- `T_CONSUME` returns to idle when any other valid instruction is accepted.
- `T_HOLD` stays in the current state on cycles with no valid instruction.

Top module: `int_exec_unit`

## Requirements
- R1: While reset is asserted, and directly after it, `out_valid`, `out_result` and `out_carry` are all zero. No prefix is pending after reset.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. On cycles without `in_valid`, `out_result` and `out_carry` keep their values.
- R3: When `in_use_imm` is 1 and no prefix is pending, the second operand B is the 16-bit immediate sign-extended to 32 bits. When `in_use_imm` is 0, B is `in_rb`. Operand A is always `in_ra`.
- R4: Opcode 0x0 (add) yields A+B modulo 2^32 and writes the carry-out of the 32-bit sum into the carry flag.
- R5: Opcode 0x1 (add, keep carry) yields A+B and leaves the carry flag unchanged.
- R6: Opcode 0x2 (reverse subtract) yields B−A and sets the carry flag to 1 exactly when B ≥ A as unsigned numbers, meaning no borrow occurred. Opcode 0x3 yields the same result and leaves the carry unchanged.
- R7: Opcodes 0x4, 0x5, 0x6 and 0x7 yield A|B, A&B, A^B and A&~B respectively. The carry flag is unchanged.
- R8: Opcode 0x8 shifts A right by one bit and replicates bit 31. The bit shifted out (A[0]) goes into the carry flag, and B has no effect.
- R9: Opcode 0x9 (prefix) stores its immediate as a pending upper half. It outputs result zero and leaves the carry unchanged. The next valid instruction with `in_use_imm`=1 uses B = {pending half, its own 16-bit immediate}.
- R10: A pending prefix is used by exactly the next valid instruction, even if that instruction takes B from `in_rb`. Cycles without `in_valid` do not use it up. A prefix that follows a prefix replaces the pending half.
- R11: Opcodes 0xA to 0xF yield result zero and leave the carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_op | input | 4 | Operation code |
| in_ra | input | 32 | Operand A register value |
| in_rb | input | 32 | Operand B register value |
| in_imm | input | 16 | Immediate field |
| in_use_imm | input | 1 | 1 selects the immediate as operand B |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Registered result |
| out_carry | output | 1 | Registered carry flag |

## Verification
Every result and carry value is due on the rising edge that follows the cycle in which its instruction was presented. The block has a single register stage, so nothing arrives later. The prefix state also changes on that same edge and therefore takes effect on the very next accepted instruction. The bench drives inputs on falling edges and pushes the expected result and carry into a queue at the same moment. A monitor compares the outputs on each later falling edge where `out_valid` is high, which is exactly one edge after issue. Idle gaps are checked by confirming that no strobe appears and that the held outputs are unchanged.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'h0,
        OP_ADDK  = 4'h1,
        OP_RSUB  = 4'h2,
        OP_RSUBK = 4'h3,
        OP_OR    = 4'h4,
        OP_AND   = 4'h5,
        OP_XOR   = 4'h6,
        OP_ANDN  = 4'h7,
        OP_SRA   = 4'h8,
        OP_PFX   = 4'h9
    } exu_op_e;

    typedef enum logic {
        PFX_IDLE  = 1'b0,
        PFX_ARMED = 1'b1
    } pfx_state_e;

endpackage

// File: rtl/exu_imm_prefix.sv
module exu_imm_prefix
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              is_pfx,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] rb,
    output logic [DATA_W-1:0] opb
);
    localparam int HI_W = DATA_W - IMM_W;

    pfx_state_e       state_q, state_d;
    logic [IMM_W-1:0] hi_q;
    logic [HI_W-1:0]  hi_ext;
    logic [DATA_W-1:0] imm_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PFX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // held upper half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (in_valid && is_pfx) begin
            hi_q <= imm;
        end
    end

    // next state: T_ARM, T_REARM, T_CONSUME, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFX_IDLE: begin
                if (in_valid && is_pfx) state_d = PFX_ARMED;
            end
            PFX_ARMED: begin
                if (in_valid && !is_pfx) state_d = PFX_IDLE;
            end
            default: state_d = PFX_IDLE;
        endcase
    end

    // upper-half width adaptation
    generate
        if (HI_W <= IMM_W) begin : g_hi_trunc
            assign hi_ext = hi_q[HI_W-1:0];
        end else begin : g_hi_sext
            assign hi_ext = {{(HI_W-IMM_W){hi_q[IMM_W-1]}}, hi_q};
        end
    endgenerate

    // outputs
    always_comb begin
        if (state_q == PFX_ARMED) begin
            imm_full = {hi_ext, imm};
        end else begin
            imm_full = {{HI_W{imm[IMM_W-1]}}, imm};
        end
        opb = use_imm ? imm_full : rb;
    end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_cur,
    output logic [DATA_W-1:0] res,
    output logic              carry_nxt
);
    localparam int EXT_W = DATA_W + 1;

    exu_op_e         op_e;
    logic [EXT_W-1:0] sum_w;
    logic [EXT_W-1:0] dif_w;

    assign op_e  = exu_op_e'(op);
    assign sum_w = {1'b0, a} + {1'b0, b};
    assign dif_w = {1'b0, b} + {1'b0, ~a} + EXT_W'(1);

    always_comb begin
        res       = '0;
        carry_nxt = carry_cur;
        case (op_e)
            OP_ADD: begin
                res       = sum_w[DATA_W-1:0];
                carry_nxt = sum_w[DATA_W];
            end
            OP_ADDK:  res = sum_w[DATA_W-1:0];
            OP_RSUB: begin
                res       = dif_w[DATA_W-1:0];
                carry_nxt = dif_w[DATA_W];
            end
            OP_RSUBK: res = dif_w[DATA_W-1:0];
            OP_OR:    res = a | b;
            OP_AND:   res = a & b;
            OP_XOR:   res = a ^ b;
            OP_ANDN:  res = a & ~b;
            OP_SRA: begin
                res       = {a[DATA_W-1], a[DATA_W-1:1]};
                carry_nxt = a[0];
            end
            OP_PFX:   res = '0;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [DATA_W-1:0] in_ra,
    input  logic [DATA_W-1:0] in_rb,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic              in_use_imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_carry
);
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] alu_res;
    logic              alu_carry;
    logic              is_pfx;

    assign is_pfx = (in_op == OP_PFX);

    exu_imm_prefix #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_pfx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .is_pfx   (is_pfx),
        .use_imm  (in_use_imm),
        .imm      (in_imm),
        .rb       (in_rb),
        .opb      (opb)
    );

    exu_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (in_op),
        .a         (in_ra),
        .b         (opb),
        .carry_cur (out_carry),
        .res       (alu_res),
        .carry_nxt (alu_carry)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_carry  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= alu_res;
                out_carry  <= alu_carry;
            end
        end
    end

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_op,
    input logic [DATA_W-1:0] in_ra,
    input logic [DATA_W-1:0] in_rb,
    input logic              in_use_imm,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_carry
);
    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_carry)));

    // R4
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_ADD && !in_use_imm) |=>
        ({out_carry, out_result} == ($past({1'b0, in_ra}) + $past({1'b0, in_rb}))));

    // R5
    keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_ADDK || in_op == OP_RSUBK)) |=> $stable(out_carry));

    // R7
    andn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_ANDN && !in_use_imm) |=>
        (out_result == ($past(in_ra) & ~$past(in_rb))));

    // R8
    sra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SRA) |=>
        (out_result == {$past(in_ra[DATA_W-1]), $past(in_ra[DATA_W-1:1])}
         && out_carry == $past(in_ra[0])));

endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_ra      (in_ra),
    .in_rb      (in_rb),
    .in_use_imm (in_use_imm),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_carry  (out_carry)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = 4'h0;
    logic [31:0] in_ra = '0;
    logic [31:0] in_rb = '0;
    logic [15:0] in_imm = '0;
    logic        in_use_imm = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_carry;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] q_res[$];
    logic        q_car[$];
    string       q_tag[$];

    logic        m_carry = 1'b0;
    logic        m_armed = 1'b0;
    logic [15:0] m_hi = '0;
    logic [31:0] m_last = '0;

    always #5 clk = ~clk;

    int_exec_unit u_int_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_ra(in_ra), .in_rb(in_rb), .in_imm(in_imm), .in_use_imm(in_use_imm),
        .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry)
    );

    task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] rb,
                         input logic [15:0] imm, input bit ui, input string tag);
        logic [31:0] b;
        logic [32:0] t;
        logic [31:0] r;
        logic        c;
        b = ui ? (m_armed ? {m_hi, imm} : {{16{imm[15]}}, imm}) : rb;
        c = m_carry;
        r = '0;
        case (op)
            4'h0: begin t = {1'b0, a} + {1'b0, b}; r = t[31:0]; c = t[32]; end
            4'h1: r = a + b;
            4'h2: begin r = b - a; c = (b >= a); end
            4'h3: r = b - a;
            4'h4: r = a | b;
            4'h5: r = a & b;
            4'h6: r = a ^ b;
            4'h7: r = a & ~b;
            4'h8: begin r = {a[31], a[31:1]}; c = a[0]; end
            default: r = '0;
        endcase
        if (op == 4'h9) begin m_armed = 1'b1; m_hi = imm; end
        else m_armed = 1'b0;
        m_carry = c;
        m_last = r;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_ra = a; in_rb = rb; in_imm = imm; in_use_imm = ui;
        q_res.push_back(r); q_car.push_back(c); q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_op = 4'hE; in_ra = 32'hDEAD_BEEF; in_rb = 32'h1234_5678; in_use_imm = 1'b1;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_res.size() == 0) begin
                check(1'b0, "R2 unexpected strobe", {out_carry, out_result}, 33'h0);
            end else begin
                logic [31:0] er;
                logic        ec;
                string       et;
                er = q_res.pop_front(); ec = q_car.pop_front(); et = q_tag.pop_front();
                check({out_carry, out_result} === {ec, er}, et, {out_carry, out_result}, {ec, er});
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({out_valid, out_result, out_carry} == '0, "R1 reset state",
              {out_carry, out_result}, 33'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check({out_valid, out_result, out_carry} == '0, "R1 after reset",
              {out_carry, out_result}, 33'h0);

        issue(4'h0, 32'd5, 32'd7, 16'h0, 1'b0, "R4 add small");
        issue(4'h0, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, "R4 add carry out");
        issue(4'h1, 32'd1, 32'd1, 16'h0, 1'b0, "R5 addk keeps carry 1");
        issue(4'h0, 32'd10, 32'h0, 16'hFFFF, 1'b1, "R3 R4 imm sign-extended negative");
        issue(4'h0, 32'd1, 32'hFFFF_FFFF, 16'h7FFF, 1'b1, "R3 imm positive ignores rb");
        issue(4'h2, 32'd3, 32'd10, 16'h0, 1'b0, "R6 rsub no borrow");
        issue(4'h2, 32'd10, 32'd3, 16'h0, 1'b0, "R6 rsub borrow");
        issue(4'h3, 32'd0, 32'd9, 16'h0, 1'b0, "R6 rsubk keeps carry");
        issue(4'h2, 32'hABCD, 32'hABCD, 16'h0, 1'b0, "R6 rsub equal");
        issue(4'h4, 32'hF0F0_0000, 32'h0000_0F0F, 16'h0, 1'b0, "R7 or");
        issue(4'h5, 32'h1234_5678, 32'h0, 16'h8000, 1'b1, "R7 and imm mask");
        issue(4'h6, 32'hFFFF_0000, 32'h0F0F_0F0F, 16'h0, 1'b0, "R7 xor");
        issue(4'h7, 32'hFFFF_FFFF, 32'h00FF_00FF, 16'h0, 1'b0, "R7 andn");
        issue(4'h8, 32'h8000_0003, 32'h5555_5555, 16'h0, 1'b0, "R8 sra negative odd");
        issue(4'h8, 32'h0000_0004, 32'h0, 16'hFFFF, 1'b1, "R8 sra even ignores b");
        idle(2);
        check(out_valid == 1'b0 && out_result == m_last && out_carry == m_carry,
              "R2 hold when idle", {out_carry, out_result}, {m_carry, m_last});
        issue(4'h9, 32'h7777_7777, 32'h0, 16'h1234, 1'b1, "R9 prefix result zero");
        issue(4'h0, 32'd1, 32'h0, 16'h8000, 1'b1, "R9 prefixed add");
        issue(4'h9, 32'h0, 32'h0, 16'hAAAA, 1'b1, "R9 prefix a");
        issue(4'h9, 32'h0, 32'h0, 16'h00FF, 1'b1, "R10 prefix replaces");
        issue(4'h4, 32'h0, 32'h0, 16'h0001, 1'b1, "R10 replaced half used");
        issue(4'h9, 32'h0, 32'h0, 16'h5555, 1'b1, "R10 prefix before reg op");
        issue(4'h4, 32'h1, 32'h2, 16'h0, 1'b0, "R10 reg op consumes prefix");
        issue(4'h4, 32'h0, 32'h0, 16'hFFFF, 1'b1, "R10 prefix gone");
        issue(4'h9, 32'h0, 32'h0, 16'h0F0F, 1'b1, "R10 prefix before gap");
        idle(3);
        issue(4'h1, 32'h10, 32'h0, 16'h0001, 1'b1, "R10 gap keeps prefix");
        issue(4'hC, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b0, "R11 undefined op");
        issue(4'hF, 32'h1, 32'h1, 16'h1, 1'b1, "R11 undefined op 2");
        idle(3);
        check(q_res.size() == 0, "R2 all results delivered",
              33'(q_res.size()), 33'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule